// File: doc/BRIEF.md
# Multi-Slot Interprocessor Mailbox

This block lets several processors pass short messages to one another through a bank of mailbox slots. Each slot holds a few data words and the bookkeeping for one message in flight. That bookkeeping is an owning processor, a set of target processors, an interrupt mask, pending interrupt bits and an auto-acknowledge option. Software reaches every slot through a plain 32-bit register bus. Each processor gets its own interrupt line. That line is the OR of every unmasked pending bit that carries its number, across all slots.

A message goes through four steps. First a processor claims an idle slot by writing its one-hot bit to the slot's owner register, and reads the register back to confirm the claim. It then picks targets and fills the data words. Writing its own bit to the send register interrupts the targets. The receiver then acknowledges the message. In manual mode it writes the send register, which interrupts the owner. In auto mode it simply clears its interrupt. Finally the owner writes its bit to the owner register again, and the slot returns to idle.

A global key register guards every slot write. Out of reset the block is locked. One magic value unlocks it, and any other value written there locks it again.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset the key register (0xA00) reads 1 (locked), every slot's mode register reads 0x10 (idle), and all cpu_irq lines are low.
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the block (key register reads 0); writing any other value relocks it (reads 1); while locked, writes to slot registers change nothing but reads still return data.
- R3: A write to the owner register (slot base + 0x00) claims the slot only if the slot is idle and the value has exactly one bit set within the processor field. The owner register then reads that value and the mode register shows the outgoing state (bit 5). Any other claim write is ignored.
- R4: While outgoing, a write of exactly the owner's value to the send register (+0x1C) moves the slot to incoming (mode bit 6) and sets a pending bit for every target processor. A send write with any other value is ignored.
- R5: A 1 in the slot mask register (+0x14) at bit c keeps processor c's pending bit of that slot off cpu_irq[c] and out of its summary register, but not out of its raw register.
- R6: Writing a value to the interrupt clear register (+0x18) clears the pending bits set in it; reading +0x18 returns the slot's pending bits.
- R7: In manual mode (mode bit 0 = 0), a nonzero write to the send register while incoming moves the slot to acknowledged (mode bit 7) and sets the owner's pending bit.
- R8: In auto mode (mode bit 0 = 1), a clear write that leaves no target's pending bit set moves an incoming slot to acknowledged without setting the owner's pending bit; send writes while incoming are ignored in this mode.
- R9: While acknowledged, a write of exactly the owner's value to the owner register returns the slot to idle and the owner register reads 0; another value leaves it acknowledged.
- R10: Writing the target set register (+0x04) ORs bits into the target set, writing +0x08 removes bits, and +0x0C reads the set.
- R11: Data word i is written and read at slot base + 0x20 + 4*i.
- R12: For processor c, 0x800 + 8*c reads one bit per slot (bit s for slot s) of its unmasked pending interrupts, and 0x804 + 8*c reads the same bits ignoring the masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one write per asserted cycle |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cpu_irq | output | NUM_CPUS | One interrupt line per processor |

## Verification
One bus write can trigger two separate effects in the same clock edge. In auto mode, a clear write removes a pending bit and also advances the slot state. A send write delivers pending bits while the mask is filtering them. Both cases are provoked with a single write. The bench then checks three things: the mode register shows both effects at once, cpu_irq drops or rises only for the unmasked processors, and the owner's bit is never set by an automatic acknowledge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OUT  = 2'd1,
      ST_IN   = 2'd2,
      ST_ACK  = 2'd3
   } mbx_state_e;

   // register offsets within a slot window
   localparam logic [5:0] OFF_OWNER = 6'h00;
   localparam logic [5:0] OFF_TSET  = 6'h04;
   localparam logic [5:0] OFF_TCLR  = 6'h08;
   localparam logic [5:0] OFF_TSTAT = 6'h0C;
   localparam logic [5:0] OFF_MODE  = 6'h10;
   localparam logic [5:0] OFF_MASK  = 6'h14;
   localparam logic [5:0] OFF_PEND  = 6'h18;
   localparam logic [5:0] OFF_SEND  = 6'h1C;
   localparam int unsigned OFF_DATA = 32'h20;

   localparam int unsigned SLOT_SPAN  = 32'h40;
   localparam int unsigned CPU_BASE   = 32'h800;
   localparam int unsigned KEY_ADDR   = 32'hA00;

   function automatic logic [3:0] state_flags(mbx_state_e st);
      logic [3:0] f;
      f = 4'b0000;
      f[st] = 1'b1;
      return f;
   endfunction

endpackage

// File: rtl/mbx_lock.sv
module mbx_lock #(
   parameter logic [31:0] KEY = 32'h1ACCE551
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [31:0] key_data,
   output logic        locked
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked <= 1'b1;
      else if (key_wr)
         locked <= (key_data != KEY);
   end

   // R2: the key opens the gate
   a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data == KEY) |=> !locked);

   // R2: any other value closes it
   a_r2_other_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data != KEY) |=> locked);

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
   import mbx_pkg::*;
#(
   parameter int NUM_CPUS   = 8,
   parameter int DATA_WORDS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [5:0]          off,
   input  logic [31:0]         wdata,
   output logic [31:0]         rdata,
   output logic [NUM_CPUS-1:0] pend_raw,
   output logic [NUM_CPUS-1:0] pend_vis
);

   localparam logic [31:0] CPU_FIELD =
      (NUM_CPUS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NUM_CPUS) - 32'd1);

   mbx_state_e          state_q;
   logic [NUM_CPUS-1:0] owner_q;
   logic [NUM_CPUS-1:0] tgt_q;
   logic [NUM_CPUS-1:0] mask_q;
   logic [NUM_CPUS-1:0] pend_q;
   logic                auto_q;
   logic [31:0]         word_q [DATA_WORDS];

   logic [NUM_CPUS-1:0] wr_cpus;
   logic                wr_in_field;
   logic                claim_ok;
   logic                is_owner_val;

   assign wr_cpus      = wdata[NUM_CPUS-1:0];
   assign wr_in_field  = ((wdata & ~CPU_FIELD) == 32'd0);
   assign claim_ok     = wr_in_field && $onehot(wr_cpus);
   assign is_owner_val = (wdata == 32'(owner_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         owner_q <= '0;
         tgt_q   <= '0;
         mask_q  <= '0;
         pend_q  <= '0;
         auto_q  <= 1'b0;
      end else if (wr_en) begin
         case (off)
            OFF_OWNER: begin
               if (state_q == ST_IDLE && claim_ok) begin
                  owner_q <= wr_cpus;
                  state_q <= ST_OUT;
               end else if (state_q == ST_ACK && is_owner_val) begin
                  owner_q <= '0;
                  state_q <= ST_IDLE;
               end
            end
            OFF_TSET:  tgt_q  <= tgt_q | wr_cpus;
            OFF_TCLR:  tgt_q  <= tgt_q & ~wr_cpus;
            OFF_MODE:  auto_q <= wdata[0];
            OFF_MASK:  mask_q <= wr_cpus;
            OFF_PEND: begin
               pend_q <= pend_q & ~wr_cpus;
               if (state_q == ST_IN && auto_q &&
                   ((pend_q & ~wr_cpus & tgt_q) == '0))
                  state_q <= ST_ACK;
            end
            OFF_SEND: begin
               if (state_q == ST_OUT && is_owner_val) begin
                  state_q <= ST_IN;
                  pend_q  <= pend_q | tgt_q;
               end else if (state_q == ST_IN && !auto_q && wr_cpus != '0) begin
                  state_q <= ST_ACK;
                  pend_q  <= pend_q | owner_q;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < DATA_WORDS; w++)
            word_q[w] <= '0;
      end else if (wr_en) begin
         for (int w = 0; w < DATA_WORDS; w++)
            if (32'(off) == OFF_DATA + 4 * w)
               word_q[w] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (off)
         OFF_OWNER: rdata = 32'(owner_q);
         OFF_TSTAT: rdata = 32'(tgt_q);
         OFF_MODE:  rdata = {24'd0, state_flags(state_q), 3'd0, auto_q};
         OFF_MASK:  rdata = 32'(mask_q);
         OFF_PEND:  rdata = 32'(pend_q);
         default: begin
            for (int w = 0; w < DATA_WORDS; w++)
               if (32'(off) == OFF_DATA + 4 * w)
                  rdata = word_q[w];
         end
      endcase
   end

   assign pend_raw = pend_q;
   assign pend_vis = pend_q & ~mask_q;

   // R3: a slot in use always has exactly one owner
   a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> $onehot(owner_q));

   // R3: claims on a busy slot leave the owner alone
   a_r3_no_steal: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_OWNER && (state_q == ST_OUT || state_q == ST_IN))
      |=> $stable(owner_q));

   // R4: owner's send delivers to every target
   a_r4_send_delivers: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_SEND && state_q == ST_OUT && is_owner_val)
      |=> (state_q == ST_IN) && ((pend_q & $past(tgt_q)) == $past(tgt_q)));

   // R8: automatic acknowledge never raises the owner's bit
   a_r8_auto_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IN && auto_q) |=> ((pend_q & owner_q & ~$past(pend_q)) == '0));

   // R9: owner's release returns the slot to idle
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_OWNER && state_q == ST_ACK && is_owner_val)
      |=> (state_q == ST_IDLE) && (owner_q == '0));

endmodule

// File: rtl/mbx_irq_map.sv
module mbx_irq_map #(
   parameter int NUM_SLOTS = 4,
   parameter int NUM_CPUS  = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_SLOTS-1:0][NUM_CPUS-1:0]  slot_vis,
   input  logic [NUM_SLOTS-1:0][NUM_CPUS-1:0]  slot_raw,
   output logic [NUM_CPUS-1:0][NUM_SLOTS-1:0]  cpu_vis,
   output logic [NUM_CPUS-1:0][NUM_SLOTS-1:0]  cpu_raw,
   output logic [NUM_CPUS-1:0]                 cpu_irq
);

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         assign cpu_vis[c][s] = slot_vis[s][c];
         assign cpu_raw[c][s] = slot_raw[s][c];
      end
      assign cpu_irq[c] = |cpu_vis[c];

      // R5: a masked view never shows a bit the raw view lacks
      a_r5_vis_within_raw: assert property (@(posedge clk) disable iff (!rst_n)
         ((cpu_vis[c] & ~cpu_raw[c]) == '0));
   end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
   import mbx_pkg::*;
#(
   parameter int          NUM_SLOTS  = 4,
   parameter int          NUM_CPUS   = 8,
   parameter int          DATA_WORDS = 2,
   parameter int          ADDR_W     = 12,
   parameter logic [31:0] UNLOCK_KEY = 32'h1ACCE551
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NUM_CPUS-1:0] cpu_irq
);

   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam int CPU_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
   localparam int unsigned SLOT_END = NUM_SLOTS * SLOT_SPAN;
   localparam int unsigned CPU_END  = CPU_BASE + 8 * NUM_CPUS;

   if (NUM_SLOTS < 1 || NUM_SLOTS > 32) begin : g_bad_slots
      $error("mbx_ctrl: NUM_SLOTS must lie in 1..32");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > 32) begin : g_bad_cpus
      $error("mbx_ctrl: NUM_CPUS must lie in 1..32");
   end
   if (DATA_WORDS < 1 || DATA_WORDS > 8) begin : g_bad_words
      $error("mbx_ctrl: DATA_WORDS must lie in 1..8");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("mbx_ctrl: ADDR_W must be at least 12");
   end

   logic [31:0]      addr32;
   logic             slot_hit, key_hit, cpu_hit, cpu_raw_sel;
   logic [SLOT_W-1:0] slot_idx;
   logic [CPU_W-1:0]  cpu_idx;
   logic             locked;

   assign addr32      = 32'(reg_addr);
   assign slot_hit    = addr32 < SLOT_END;
   assign key_hit     = addr32 == KEY_ADDR;
   assign cpu_hit     = addr32 >= CPU_BASE && addr32 < CPU_END && addr32[1:0] == 2'b00;
   assign cpu_raw_sel = addr32[2];
   assign slot_idx    = addr32[6 +: SLOT_W];
   assign cpu_idx     = addr32[3 +: CPU_W];

   mbx_lock #(.KEY(UNLOCK_KEY)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (reg_wr && key_hit),
      .key_data (reg_wdata),
      .locked   (locked)
   );

   logic [31:0]                        slot_rdata [NUM_SLOTS];
   logic [NUM_SLOTS-1:0][NUM_CPUS-1:0] slot_vis;
   logic [NUM_SLOTS-1:0][NUM_CPUS-1:0] slot_raw;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic sel_wr;
      assign sel_wr = reg_wr && !locked && slot_hit && (32'(slot_idx) == s);
      mbx_slot #(.NUM_CPUS(NUM_CPUS), .DATA_WORDS(DATA_WORDS)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (sel_wr),
         .off      (addr32[5:0]),
         .wdata    (reg_wdata),
         .rdata    (slot_rdata[s]),
         .pend_raw (slot_raw[s]),
         .pend_vis (slot_vis[s])
      );
   end

   logic [NUM_CPUS-1:0][NUM_SLOTS-1:0] cpu_vis;
   logic [NUM_CPUS-1:0][NUM_SLOTS-1:0] cpu_raw;

   mbx_irq_map #(.NUM_SLOTS(NUM_SLOTS), .NUM_CPUS(NUM_CPUS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_vis (slot_vis),
      .slot_raw (slot_raw),
      .cpu_vis  (cpu_vis),
      .cpu_raw  (cpu_raw),
      .cpu_irq  (cpu_irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (slot_hit)
         reg_rdata = slot_rdata[slot_idx];
      else if (key_hit)
         reg_rdata = {31'd0, locked};
      else if (cpu_hit)
         reg_rdata = cpu_raw_sel ? 32'(cpu_raw[cpu_idx]) : 32'(cpu_vis[cpu_idx]);
   end

   // R2: a slot write while locked leaves pending state and interrupts untouched
   a_r2_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && locked && slot_hit) |=> ($stable(slot_raw) && $stable(cpu_irq)));

endmodule

// File: tb/mbx_ctrl_bench.sv
`timescale 1ns/1ps
module mbx_ctrl_bench;

   localparam int NCPU = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCPU-1:0] cpu_irq;

   always #2.5 clk = ~clk;

   mbx_ctrl u_mbx_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cpu_irq   (cpu_irq)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   bit    mon_en = 1'b0;
   int    n_cmp = 0;
   int    n_bad = 0;

   // monitor: pops one expected item per probed cycle
   always @(negedge clk) begin
      #1;
      if (mon_en) begin
         item_t it;
         logic [31:0] act;
         it  = q.pop_front();
         act = it.is_irq ? 32'(cpu_irq) : reg_rdata;
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic probe(input bit irq, input logic [11:0] a,
                        input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      reg_addr = a;
      it.is_irq = irq; it.exp = e; it.tag = tag;
      q.push_back(it);
      mon_en = 1'b1;
      @(negedge clk);
      mon_en = 1'b0;
   endtask

   task automatic chk(input logic [11:0] a, input logic [31:0] e, input string tag);
      probe(1'b0, a, e, tag);
   endtask

   task automatic chk_irq(input logic [31:0] e, input string tag);
      probe(1'b1, 12'h000, e, tag);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(12'hA00, 32'h1, "R1 locked after reset");
      chk(12'h010, 32'h10, "R1 slot0 idle");
      chk(12'h090, 32'h10, "R1 slot2 idle");
      chk_irq(32'h0, "R1 irq low");

      // R2 writes ignored while locked
      wr(12'h044, 32'h2);
      chk(12'h04C, 32'h0, "R2 locked write ignored");
      wr(12'hA00, 32'h1ACCE551);
      chk(12'hA00, 32'h0, "R2 key unlocks");

      // R3 claim of slot1 by cpu0
      wr(12'h040, 32'h1);
      chk(12'h040, 32'h1, "R3 claim owner");
      chk(12'h050, 32'h20, "R3 outgoing");
      wr(12'h040, 32'h4);
      chk(12'h040, 32'h1, "R3 busy claim ignored");
      wr(12'h080, 32'h3);
      chk(12'h080, 32'h0, "R3 non-onehot claim ignored");
      chk(12'h090, 32'h10, "R3 slot2 stays idle");

      // R10 target set / clear
      wr(12'h044, 32'h6);
      wr(12'h048, 32'h4);
      chk(12'h04C, 32'h2, "R10 set then clear");
      wr(12'h044, 32'h4);
      chk(12'h04C, 32'h6, "R10 set again");

      // R5 mask cpu2, R11 data words
      wr(12'h054, 32'h4);
      chk(12'h054, 32'h4, "R5 mask readback");
      wr(12'h060, 32'hDEADBEEF);
      wr(12'h064, 32'h12345678);
      chk(12'h060, 32'hDEADBEEF, "R11 data word 0");
      chk(12'h064, 32'h12345678, "R11 data word 1");

      // R4 send: wrong value ignored, owner's value delivers
      wr(12'h050, 32'h0);
      wr(12'h05C, 32'h2);
      chk(12'h050, 32'h20, "R4 foreign send ignored");
      chk_irq(32'h0, "R4 no irq before send");
      wr(12'h05C, 32'h1);
      chk(12'h050, 32'h40, "R4 incoming");
      chk(12'h058, 32'h6, "R6 pending readback");
      chk_irq(32'h2, "R5 masked cpu2 off irq");
      chk(12'h808, 32'h2, "R12 cpu1 summary slot1");
      chk(12'h810, 32'h0, "R5 cpu2 summary masked");
      chk(12'h814, 32'h2, "R12 cpu2 raw shows slot1");

      // R6 clear
      wr(12'h058, 32'h6);
      chk(12'h058, 32'h0, "R6 pending cleared");
      chk_irq(32'h0, "R6 irq dropped");
      chk(12'h050, 32'h40, "R6 manual stays incoming");

      // R7 manual acknowledge
      wr(12'h05C, 32'h2);
      chk(12'h050, 32'h80, "R7 acknowledged");
      chk(12'h058, 32'h1, "R7 owner pending");
      chk_irq(32'h1, "R7 sender irq");
      chk(12'h800, 32'h2, "R12 cpu0 summary slot1");

      // R9 release
      wr(12'h058, 32'h1);
      wr(12'h040, 32'h2);
      chk(12'h050, 32'h80, "R9 foreign release ignored");
      wr(12'h040, 32'h1);
      chk(12'h050, 32'h10, "R9 idle after release");
      chk(12'h040, 32'h0, "R9 owner cleared");

      // R2 relock: reads work, writes ignored
      wr(12'hA00, 32'h0);
      chk(12'hA00, 32'h1, "R2 relocked");
      wr(12'h060, 32'h0);
      chk(12'h060, 32'hDEADBEEF, "R2 data kept while locked");
      wr(12'hA00, 32'h1ACCE551);

      // R8 auto acknowledge on slot2, cpu3 to cpu4
      wr(12'h080, 32'h8);
      wr(12'h084, 32'h10);
      wr(12'h090, 32'h1);
      chk(12'h090, 32'h21, "R8 auto mode outgoing");
      wr(12'h09C, 32'h8);
      chk(12'h090, 32'h41, "R8 incoming");
      chk_irq(32'h10, "R8 target irq");
      chk(12'h820, 32'h4, "R12 cpu4 summary slot2");
      wr(12'h09C, 32'h10);
      chk(12'h090, 32'h41, "R8 send ignored in auto");
      wr(12'h098, 32'h10);
      chk(12'h090, 32'h81, "R8 clear acknowledges");
      chk(12'h098, 32'h0, "R8 no sender pending");
      chk_irq(32'h0, "R8 no irq after auto ack");
      wr(12'h080, 32'h8);
      chk(12'h090, 32'h11, "R9 auto slot released");

      repeat (3) @(negedge clk);
      if (q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL queue: actual %0d expected 0 left", q.size());
      end
      summary();
      $finish;
   end

endmodule